// File: doc/BRIEF.md
# Ethernet transmit pad and FCS inserter

This block sits between a transmit word FIFO and the MAC serializer. Software, or an upstream DMA engine, writes one frame into the FIFO. The first word is a header whose low 16 bits give the frame data length L. L counts the destination address, source address, length/type and payload bytes, and excludes the check sequence. The frame bytes follow, four per 32-bit word. The block unpacks them into a byte stream with a valid/ready handshake and a last flag.

Two switches act independently of each other. With padding on, a frame whose data is shorter than 60 bytes is extended with zero bytes to 60 bytes, which is a 46-byte payload behind the 14-byte header. With check generation on, the block computes the IEEE 802.3 CRC-32 over every emitted data and pad byte and appends it. With check generation off, the four check bytes are read from the FIFO right after the data, so a test can put a deliberately wrong CRC on the wire. Both switches are sampled once per frame, when the header word is taken.

The controller has five states:
- ST_IDLE waits for a header word.
- ST_DATA forwards the L FIFO bytes.
- ST_PAD emits zero bytes.
- ST_FCS_GEN emits the computed check.
- ST_FCS_PASS forwards four FIFO check bytes.

Its transitions are:
- IDLE→DATA when L>0.
- IDLE→PAD when L=0 and padding is on.
- IDLE→FCS_GEN or IDLE→FCS_PASS when L=0 and padding is off.
- DATA→PAD on the last data byte of a short frame with padding on.
- DATA→FCS_GEN or DATA→FCS_PASS on the last data byte otherwise.
- PAD→FCS_GEN or PAD→FCS_PASS on the 60th byte.
- FCS_GEN→IDLE and FCS_PASS→IDLE on the fourth check byte.

Top module: `eth_tx_pad_fcs`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: Within each FIFO word, bits 7:0 are emitted first, then 15:8, then 23:16, then 31:24.
- R3: The header word's bits 15:0 give L, and its bits 31:16 are ignored. The L bytes after the header are emitted in order. Unused bytes in a frame's final word are discarded, and the next frame's header is the next word.
- R4: With padding on and L<60, zero bytes follow the data until 60 data-plus-pad bytes have been emitted.
- R5: With padding off, or with L of 60 or more, no pad byte is inserted and the check bytes follow the data directly.
- R6: With generation on, four check bytes follow. They are the CRC-32 with reflected polynomial 0xEDB88320, preset all ones and final inversion, taken over all data and pad bytes, with the least significant byte first.
- R7: With generation off, the four FIFO bytes that follow the data are emitted unchanged as the check field, after any pad bytes.
- R8: out_last is 1 on the final check byte of each frame and on no other byte.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R10: The pad and check settings take effect only when a frame's header is accepted. Changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pad_en | input | 1 | Enable zero padding of short frames |
| cfg_fcs_en | input | 1 | Enable computed check sequence |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Block accepts the FIFO word |
| in_data | input | 32 | FIFO word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Serializer accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The checker watches four things on every cycle. It confirms that the output holds steady under backpressure. It counts handshakes to confirm that each frame ends exactly at max(L, 60 if padding) plus four bytes. It confirms that every byte in the pad window is zero. It confirms that a generated check leaves the standard CRC-32 residue over the whole frame.

Only the bench's scenarios can show the rest:
- the byte order within a word and discarding of leftover bytes;
- passing through deliberately wrong FIFO check bytes;
- the exact check value against the known "123456789" vector;
- settings being held when they change mid-frame;
- correct behaviour across every length from 0 to 70 under several ready patterns.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_FCS_GEN,
        ST_FCS_PASS
    } tx_state_e;

    localparam int CRC_W     = 32;
    localparam int FCS_BYTES = CRC_W / 8;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB20E3;

    function automatic logic [CRC_W-1:0] crc32_step(input logic [CRC_W-1:0] c,
                                                    input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {24'h000000, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_unpack.sv
module eth_tx_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [BYTE_W-1:0] cur_byte,
    input  logic              pop_byte,
    input  logic              pop_word
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    logic              full_q;
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] lane_byte [LANES];
    logic              lane_end;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    assign lane_end   = (lane_q == LANE_W'(LANES - 1));
    assign cur_byte   = lane_byte[lane_q];
    assign in_ready   = !full_q;
    assign word_valid = full_q;
    assign word_data  = word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            lane_q <= '0;
            word_q <= '0;
        end else if (pop_word || (pop_byte && lane_end)) begin
            full_q <= 1'b0;
            lane_q <= '0;
        end else if (pop_byte) begin
            lane_q <= lane_q + LANE_W'(1);
        end else if (!full_q && in_valid) begin
            full_q <= 1'b1;
            word_q <= in_data;
            lane_q <= '0;
        end
    end

endmodule

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] fcs_out
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else if (clear) begin
            crc_q <= CRC_PRESET;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, data_in);
        end
    end

    assign fcs_out = ~crc_q;

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pad_en,
    input  logic              cfg_fcs_en,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic [7:0]        cur_byte,
    input  logic [CRC_W-1:0]  fcs_val,
    input  logic              out_ready,
    output logic              pop_byte,
    output logic              pop_word,
    output logic              crc_clear,
    output logic              crc_en,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output tx_state_e         state,
    output logic              pad_q,
    output logic              fcs_q,
    output logic [LEN_W-1:0]  len_q
);
    localparam int FCNT_W = $clog2(FCS_BYTES);

    tx_state_e         state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic              fire;
    logic              last_data;
    logic              pad_last;
    logic              fcs_last;
    logic              short_frame;
    logic [LEN_W-1:0]  hdr_len;
    logic [CRC_W-1:0]  fcs_shift;
    tx_state_e         fcs_state;

    assign fire        = out_valid && out_ready;
    assign hdr_len     = word_data[LEN_W-1:0];
    assign last_data   = (cnt_q == len_q - LEN_W'(1));
    assign pad_last    = (cnt_q == LEN_W'(MIN_LEN - 1));
    assign fcs_last    = (fcnt_q == FCNT_W'(FCS_BYTES - 1));
    assign short_frame = pad_q && (len_q < LEN_W'(MIN_LEN));
    assign fcs_shift   = fcs_val >> (32'(fcnt_q) * 8);
    assign fcs_state   = fcs_q ? ST_FCS_GEN : ST_FCS_PASS;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (word_valid) begin
                    if (hdr_len != '0) begin
                        state_d = ST_DATA;
                    end else if (cfg_pad_en) begin
                        state_d = ST_PAD;
                    end else if (cfg_fcs_en) begin
                        state_d = ST_FCS_GEN;
                    end else begin
                        state_d = ST_FCS_PASS;
                    end
                end
            end
            ST_DATA: begin
                if (fire && last_data) begin
                    state_d = short_frame ? ST_PAD : fcs_state;
                end
            end
            ST_PAD: begin
                if (fire && pad_last) begin
                    state_d = fcs_state;
                end
            end
            ST_FCS_GEN, ST_FCS_PASS: begin
                if (fire && fcs_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // frame context and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fcnt_q <= '0;
            len_q  <= '0;
            pad_q  <= 1'b0;
            fcs_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && word_valid) begin
                len_q  <= hdr_len;
                pad_q  <= cfg_pad_en;
                fcs_q  <= cfg_fcs_en;
                cnt_q  <= '0;
                fcnt_q <= '0;
            end else if (fire && (state_q == ST_DATA || state_q == ST_PAD)) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end else if (fire) begin
                fcnt_q <= fcnt_q + FCNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        pop_byte  = 1'b0;
        pop_word  = 1'b0;
        crc_clear = 1'b0;
        crc_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pop_word  = word_valid;
                crc_clear = word_valid;
            end
            ST_DATA: begin
                out_valid = word_valid;
                out_data  = cur_byte;
                crc_en    = fire;
                if (fire && last_data && fcs_q) begin
                    pop_word = 1'b1;
                end else if (fire) begin
                    pop_byte = 1'b1;
                end
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_data  = 8'h00;
                crc_en    = fire;
            end
            ST_FCS_GEN: begin
                out_valid = 1'b1;
                out_data  = fcs_shift[7:0];
                out_last  = fcs_last;
            end
            ST_FCS_PASS: begin
                out_valid = word_valid;
                out_data  = cur_byte;
                out_last  = fcs_last;
                if (fire && fcs_last) begin
                    pop_word = 1'b1;
                end else if (fire) begin
                    pop_byte = 1'b1;
                end
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/eth_tx_pad_fcs.sv
module eth_tx_pad_fcs
    import eth_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pad_en,
    input  logic              cfg_fcs_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    logic              word_valid;
    logic [WORD_W-1:0] word_data;
    logic [7:0]        cur_byte;
    logic              pop_byte;
    logic              pop_word;
    logic              crc_clear;
    logic              crc_en;
    logic [CRC_W-1:0]  fcs_val;
    tx_state_e         state;
    logic              pad_q;
    logic              fcs_q;
    logic [LEN_W-1:0]  len_q;

    eth_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(8)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .word_valid (word_valid),
        .word_data  (word_data),
        .cur_byte   (cur_byte),
        .pop_byte   (pop_byte),
        .pop_word   (pop_word)
    );

    eth_tx_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .en      (crc_en),
        .data_in (out_data),
        .fcs_out (fcs_val)
    );

    eth_tx_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pad_en (cfg_pad_en),
        .cfg_fcs_en (cfg_fcs_en),
        .word_valid (word_valid),
        .word_data  (word_data),
        .cur_byte   (cur_byte),
        .fcs_val    (fcs_val),
        .out_ready  (out_ready),
        .pop_byte   (pop_byte),
        .pop_word   (pop_word),
        .crc_clear  (crc_clear),
        .crc_en     (crc_en),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .state      (state),
        .pad_q      (pad_q),
        .fcs_q      (fcs_q),
        .len_q      (len_q)
    );

endmodule

// File: rtl/eth_tx_chk.sv
module eth_tx_chk
    import eth_tx_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input tx_state_e        state,
    input logic             pad_q,
    input logic             fcs_q,
    input logic [LEN_W-1:0] len_q
);
    logic             fire;
    logic [LEN_W:0]   cnt_q;
    logic [LEN_W:0]   exp_tot;
    logic [CRC_W-1:0] res_q;

    assign fire    = out_valid && out_ready;
    assign exp_tot = ((pad_q && (len_q < LEN_W'(MIN_LEN))) ? (LEN_W+1)'(MIN_LEN)
                                                            : {1'b0, len_q})
                     + (LEN_W+1)'(FCS_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            res_q <= CRC_PRESET;
        end else if (fire && out_last) begin
            cnt_q <= '0;
            res_q <= CRC_PRESET;
        end else if (fire) begin
            cnt_q <= cnt_q + (LEN_W+1)'(1);
            res_q <= crc32_step(res_q, out_data);
        end
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |-> (cnt_q + (LEN_W+1)'(1) == exp_tot));

    p_no_early_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !out_last) |-> (cnt_q + (LEN_W+1)'(1) < exp_tot));

    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cnt_q >= {1'b0, len_q}) && (cnt_q < exp_tot - (LEN_W+1)'(FCS_BYTES)))
        |-> (out_data == 8'h00));

    p_fcs_residue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last && fcs_q) |-> (crc32_step(res_q, out_data) == CRC_RESIDUE));

    p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(pad_q) && $stable(fcs_q)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !out_valid);

endmodule

bind eth_tx_pad_fcs eth_tx_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .state     (state),
    .pad_q     (pad_q),
    .fcs_q     (fcs_q),
    .len_q     (len_q)
);

// File: tb/sim_eth_tx_pad_fcs.sv
`timescale 1ns/1ps
module sim_eth_tx_pad_fcs;

    localparam int NLEN = 71;
    localparam int NF   = 1 + 4 * NLEN;
    localparam int MINL = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pad_en = 1'b0;
    logic        cfg_fcs_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  exp_b [0:127];

    always #2 clk = ~clk;

    eth_tx_pad_fcs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pad_en(cfg_pad_en), .cfg_fcs_en(cfg_fcs_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    function automatic int f_len(int k);
        return (k == 0) ? 9 : (k - 1) % NLEN;
    endfunction
    function automatic bit f_pad(int k);
        return (k == 0) ? 1'b0 : (((k - 1) / NLEN) % 2 == 1);
    endfunction
    function automatic bit f_fcs(int k);
        return (k == 0) ? 1'b1 : (((k - 1) / NLEN) / 2 == 0);
    endfunction
    function automatic logic [7:0] f_data(int k, int i);
        return (k == 0) ? 8'(8'h31 + i) : 8'((k * 29 + i * 7 + 3) & 255);
    endfunction
    function automatic logic [7:0] f_ffcs(int k, int i);
        return 8'((8'hC0 ^ k ^ (i * 17)) & 255);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic producer();
        for (int k = 0; k < NF; k++) begin
            int L = f_len(k);
            int n = L + (f_fcs(k) ? 0 : 4);
            int nw = (n + 3) / 4;
            push({16'hA5A5, 16'(L)});
            for (int w = 0; w < nw; w++) begin
                logic [31:0] word;
                for (int b = 0; b < 4; b++) begin
                    int p = w * 4 + b;
                    logic [7:0] v;
                    if (p < L) v = f_data(k, p);
                    else if (p < n) v = f_ffcs(k, p - L);
                    else v = 8'hEE;
                    word[b*8 +: 8] = v;
                end
                push(word);
            end
            if (k % 5 == 4) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consumer();
        for (int k = 0; k < NF; k++) begin
            int L = f_len(k);
            bit pd = f_pad(k);
            bit fc = f_fcs(k);
            int body = (pd && L < MINL) ? MINL : L;
            int n = body + 4;
            logic [31:0] c = 32'hFFFFFFFF;
            int idx = 0;
            bit stall = 0;
            logic [7:0] sdata = 0;
            cfg_pad_en = pd;
            cfg_fcs_en = fc;
            for (int i = 0; i < body; i++) begin
                exp_b[i] = (i < L) ? f_data(k, i) : 8'h00;
                c = c ^ {24'h0, exp_b[i]};
                for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
            c = ~c;
            if (k == 0) c = 32'hCBF43926;
            for (int i = 0; i < 4; i++) exp_b[body + i] = fc ? c[i*8 +: 8] : f_ffcs(k, i);
            while (idx < n) begin
                string tag;
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (k % 3)
                    0: out_ready = 1'b1;
                    1: out_ready = lfsr[0] | lfsr[1];
                    default: out_ready = cycles[0];
                endcase
                #0.5;
                if (stall) check(out_valid && out_data == sdata, "R9 hold", int'(out_data), int'(sdata));
                if (out_valid && out_ready) begin
                    if (idx < L) tag = (k == 0) ? "R2 data" : "R3 data";
                    else if (idx < body) tag = "R4 pad";
                    else if (!pd && L < MINL) tag = fc ? "R5/R6 fcs" : "R5/R7 fcs";
                    else tag = fc ? "R6/R10 fcs" : "R7/R10 fcs";
                    check(out_data == exp_b[idx], tag, int'(out_data), int'(exp_b[idx]));
                    check(out_last == (idx == n - 1), "R8 last", int'(out_last), int'(idx == n - 1));
                    idx++;
                    if (idx == 1) begin
                        cfg_pad_en = ~pd;
                        cfg_fcs_en = ~fc;
                    end
                end
                stall = out_valid && !out_ready;
                sdata = out_data;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            producer();
            consumer();
        join
        repeat (4) @(negedge clk);
        #0.5;
        check(out_valid == 1'b0, "R3 idle after frames", int'(out_valid), 0);
        finish_run();
    end

endmodule